// File: doc/BRIEF.md
# Reset Cause Controller

The block merges five reset requests into one internal reset and keeps a record of which requests caused it. Four requests are levels: power-on, brown-out, the external reset pin and a debug-port reset bit. The fifth is a watchdog expiry. When the expiry input rises, the block turns it into a reset pulse exactly one clock wide. After every request has gone away, a counter keeps the internal reset asserted for a fixed number of clocks.

A 5-bit flag register records the cause and reads back as an 8-bit status byte. Software clears a flag by writing zero to its bit through a write strobe with 8-bit data. Writing one to a bit leaves that flag as it was. A power-on request wipes every other flag and sets only its own. The power-on flag can be cleared only by software. The register stays writable while the internal reset is stretched, but not while power-on is asserted.

Top module: `reset_cause_unit`

## Requirements
- R1: The status byte has the debug flag at bit 4, the watchdog flag at bit 3, the brown-out flag at bit 2, the external flag at bit 1 and the power-on flag at bit 0. Bits 7 to 5 always read zero, and writes to them have no effect.
- R2: While power-on is asserted, the status becomes 0x01 one clock later. Software writes made during power-on are ignored.
- R3: An active brown-out, external or debug request sets its own flag (bit 2, 1 or 4). Requests that are active together all set their flags.
- R4: A rising edge on the watchdog expiry input drives wd_reset high for exactly one clock, starting one clock after the edge. The pulse sets the watchdog flag (bit 3).
- R5: A write with wr_en clears each flag whose wr_data bit is 0 and leaves each flag whose wr_data bit is 1 unchanged.
- R6: If a request sets a flag in the same cycle that a write clears it, the flag ends up set.
- R7: sys_rst is high while any level request is active. After the last request drops, it stays high for exactly RELEASE_CYCLES clocks.
- R8: For a watchdog reset, the release count starts once the pulse falls. sys_rst goes low exactly RELEASE_CYCLES+2 clocks after the expiry edge is sampled.
- R9: Writes take effect while sys_rst is held by the release counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset request, level |
| bod_req | input | 1 | Brown-out reset request, level |
| ext_req | input | 1 | External pin reset request, level |
| dbg_req | input | 1 | Debug-port reset-register bit, level |
| wdt_timeout | input | 1 | Watchdog expiry, rising edge triggers |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 8 | Status write data (0 clears a flag) |
| status | output | 8 | Status byte |
| wd_reset | output | 1 | One-clock watchdog reset pulse |
| sys_rst | output | 1 | Stretched internal reset |

## Verification
The bench builds the block with RELEASE_CYCLES set to 6. With this value, every release window can be counted edge by edge, including the two extra clocks on the watchdog path. The short window also lets random traffic overlap new requests with a release count that is still running. Those overlaps exercise the counter reload and the rule that a set beats a clear, across many flag combinations.

// File: rtl/reset_cause_unit.sv
module reset_cause_unit #(
  parameter int unsigned RELEASE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       por_req,
  input  logic       bod_req,
  input  logic       ext_req,
  input  logic       dbg_req,
  input  logic       wdt_timeout,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] status,
  output logic       wd_reset,
  output logic       sys_rst
);
  localparam int CW = $clog2(RELEASE_CYCLES + 1);

  logic [4:0]    flags;
  logic          wd_prev;
  logic [CW-1:0] hold_cnt;

  wire [4:0] src     = {dbg_req, wd_reset, bod_req, ext_req, por_req};
  wire       any_src = |src;

  always_ff @(posedge clk) begin
    wd_prev  <= wdt_timeout;
    wd_reset <= wdt_timeout & ~wd_prev;
  end

  always_ff @(posedge clk) begin
    if (por_req)
      flags <= 5'b00001;
    else
      flags <= (wr_en ? (flags & wr_data[4:0]) : flags) | src;
  end

  always_ff @(posedge clk) begin
    if (any_src)
      hold_cnt <= CW'(RELEASE_CYCLES);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end

  assign sys_rst = any_src | (hold_cnt != '0);
  assign status  = {3'b000, flags};

  p_por_only_r2: assert property (@(posedge clk) disable iff (por_req)
    $past(por_req) |-> (flags == 5'b00001));

  p_set_flags_r3: assert property (@(posedge clk) disable iff (por_req)
    any_src |=> ((flags & $past(src)) == $past(src)));

  p_wd_one_clock_r4: assert property (@(posedge clk) disable iff (por_req)
    wd_reset |=> !wd_reset);

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (por_req)
    (wr_en && !any_src) |=> ((flags & ~$past(wr_data[4:0])) == 5'b0));

  p_hold_r7: assert property (@(posedge clk) disable iff (por_req)
    any_src |=> sys_rst);
endmodule

// File: tb/tb_reset_cause_unit.sv
module tb_reset_cause_unit;
  localparam int D = 6;

  logic clk = 1'b0;
  logic por_req = 1'b0, bod_req = 1'b0, ext_req = 1'b0, dbg_req = 1'b0;
  logic wdt_timeout = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status;
  logic wd_reset, sys_rst;

  int n_cmp = 0, n_bad = 0;
  logic [4:0] m_flags = 5'b0;
  logic m_prev = 1'b0, m_pulse = 1'b0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  reset_cause_unit #(.RELEASE_CYCLES(D)) dut (
    .clk(clk), .por_req(por_req), .bod_req(bod_req), .ext_req(ext_req),
    .dbg_req(dbg_req), .wdt_timeout(wdt_timeout), .wr_en(wr_en),
    .wr_data(wr_data), .status(status), .wd_reset(wd_reset), .sys_rst(sys_rst)
  );

  function automatic logic [4:0] next_flags(logic [4:0] f, logic [4:0] s,
                                            logic we, logic [7:0] wd);
    if (s[0]) return 5'b00001;
    return (we ? (f & wd[4:0]) : f) | s;
  endfunction

  function automatic logic [4:0] cur_src();
    return {dbg_req, m_pulse, bod_req, ext_req, por_req};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_model(string req);
    check(req, status, {3'b0, m_flags});
    check(req, {7'b0, wd_reset}, {7'b0, m_pulse});
    check(req, {7'b0, sys_rst}, {7'b0, ((|cur_src()) || m_cnt != 0)});
  endtask

  task automatic step();
    logic [4:0] s;
    @(posedge clk);
    s = cur_src();
    m_flags = next_flags(m_flags, s, wr_en, wr_data);
    m_cnt   = (|s) ? D : (m_cnt > 0 ? m_cnt - 1 : 0);
    m_pulse = wdt_timeout & ~m_prev;
    m_prev  = wdt_timeout;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  initial begin
    #(5 * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    por_req = 1'b1;
    repeat (3) step();
    check("R2 por status", status, 8'h01);
    check("R7 held in por", {7'b0, sys_rst}, 8'h01);
    wr(8'h00);
    check("R2 write ignored in por", status, 8'h01);

    por_req = 1'b0;
    for (int k = 1; k <= D; k++) begin
      step();
      check("R7 por release", {7'b0, sys_rst}, {7'b0, k < D});
    end

    wr(8'hFF);
    check("R1 R5 write ones", status, 8'h01);
    wr(8'hE0);
    check("R5 write zero clears", status, 8'h00);

    bod_req = 1'b1; step(); step();
    check("R3 brown-out", status, 8'h04);
    bod_req = 1'b0;
    for (int k = 1; k <= D; k++) begin
      step();
      check("R7 exact release", {7'b0, sys_rst}, {7'b0, k < D});
    end

    ext_req = 1'b1; dbg_req = 1'b1; step();
    check("R3 multiple", status, 8'h16);
    ext_req = 1'b0; dbg_req = 1'b0;
    wr(8'h00);
    check("R9 write during hold", status, 8'h00);
    check("R9 still held", {7'b0, sys_rst}, 8'h01);
    repeat (D) step();
    check("R7 idle", {7'b0, sys_rst}, 8'h00);

    wdt_timeout = 1'b1;
    for (int k = 1; k <= D + 2; k++) begin
      step();
      if (k == 1) check("R4 pulse high", {7'b0, wd_reset}, 8'h01);
      if (k == 2) check("R4 pulse one clock", {7'b0, wd_reset}, 8'h00);
      check("R8 wd release", {7'b0, sys_rst}, {7'b0, k < D + 2});
    end
    check("R4 wd flag", status, 8'h08);
    wdt_timeout = 1'b0;

    bod_req = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    step();
    wr_en = 1'b0; bod_req = 1'b0;
    check("R6 set beats clear", status, 8'h04);

    dbg_req = 1'b1; step(); dbg_req = 1'b0;
    por_req = 1'b1; step(); por_req = 1'b0;
    check("R2 por wipes others", status, 8'h01);
    repeat (D) step();

    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom(i == 0 ? 32'd7 : 32'd0) & 0;
      r = $urandom;
      por_req     = (r[3:0] == 4'd0) && r[20];
      bod_req     = r[6:4] == 3'd0;
      ext_req     = r[9:7] == 3'd0;
      dbg_req     = r[12:10] == 3'd0;
      wdt_timeout = r[13];
      wr_en       = r[14];
      wr_data     = $urandom;
      step();
      compare_model("R1 R3 R5 R6 R7 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule